// File: doc/BRIEF.md
# RRIP Set Replacement Engine

This block keeps the replacement metadata for a single 16-way set of a last-level cache. Every way carries a valid flag, a 2-bit re-reference prediction value (RRPV), a reuse flag and the 14-bit signature of the access that brought the line in. A hit marks the way as about to be reused. A miss runs a victim search. It fills an empty way if one exists. Otherwise it evicts a way predicted distant, and when none is distant it ages the whole set one step per cycle until one becomes distant.

An external predictor supplies the RRPV given to the incoming line with each miss. When a valid line is evicted, the engine reports that line's reuse flag and its stored signature, so the predictor can be trained in the same cycle that the new line is installed. A ready signal drops while a miss is being resolved, and requests presented during that time are not accepted.

Top module: `rrip_set_engine`

## Requirements
- R1: After reset every way is empty, `req_ready` is 1, and `resp_valid` and `evict_valid` are 0.
- R2: An accepted hit (`req_valid`, `req_ready` and `req_hit` all 1) to a filled way sets that way's RRPV to 0 and its reuse flag to 1. The engine stays ready and gives no response.
- R3: A hit naming an empty way changes nothing. That way is still the one filled when its turn comes, and it holds a clear reuse flag afterwards.
- R4: A miss accepted while any way is empty fills the lowest-numbered empty way in the cycle after acceptance, with `resp_valid` 1 and `evict_valid` 0.
- R5: A miss accepted while all ways are filled selects as victim the lowest-numbered way whose RRPV is 3 (distant).
- R6: When no way holds RRPV 3, each search cycle raises every way's RRPV by one (saturating at 3) and gives no response. The response therefore arrives 1 to 4 cycles after acceptance.
- R7: Eviction of a filled line gives a one-cycle `evict_valid` pulse, coincident with `resp_valid`. In that pulse `evict_reuse` and `evict_sig` carry the victim's reuse flag and signature as they stood before replacement.
- R8: The installed line takes its RRPV from `req_insert_rrpv` and its signature from `req_sig`, both as sampled when the miss was accepted, and its reuse flag is cleared.
- R9: `req_ready` is 0 from the cycle after a miss is accepted through the cycle carrying `resp_valid`, and 1 in the cycle after that. Requests presented while `req_ready` is 0 are ignored.
- R10: `resp_way` is the binary index (0 to 15) of the way that was filled or replaced. It is valid while `resp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_hit | input | 1 | 1: hit to `req_way`; 0: miss |
| req_way | input | 4 | Way touched by a hit |
| req_sig | input | 14 | Signature of the missing access |
| req_insert_rrpv | input | 2 | RRPV to give the line installed by this miss |
| req_ready | output | 1 | Engine can accept a request |
| resp_valid | output | 1 | Miss resolved this cycle |
| resp_way | output | 4 | Way filled or replaced |
| evict_valid | output | 1 | A filled line is being evicted |
| evict_reuse | output | 1 | Reuse flag of the evicted line |
| evict_sig | output | 14 | Signature stored with the evicted line |

## Verification
Two things happen in the cycle that resolves a miss against a full set: the victim's old metadata is exported, and the new line overwrites the same way. The bench provokes this by loading ways with known signatures and hit histories and then missing with a different signature. It checks that `evict_sig` and `evict_reuse` show the departing line and not the arriving one. Later evictions of the installed line then show the new signature with a clear reuse flag. The bench also presents hits while a miss is pending, to confirm that the aging loop and the hit update never share a cycle.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } rrip_state_e;

endpackage

// File: rtl/rrip_first_sel.sv
module rrip_first_sel #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |mask;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/rrip_way_meta.sv
module rrip_way_meta #(
  parameter int RRPV_W = 2,
  parameter int SIG_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              fill_i,
  input  logic              age_i,
  input  logic [RRPV_W-1:0] fill_rrpv_i,
  input  logic [SIG_W-1:0]  fill_sig_i,
  output logic              valid_o,
  output logic [RRPV_W-1:0] rrpv_o,
  output logic              reuse_o,
  output logic [SIG_W-1:0]  sig_o
);

  localparam logic [RRPV_W-1:0] RRPV_MAX = {RRPV_W{1'b1}};

  // saturating one-step aging
  function automatic logic [RRPV_W-1:0] age_sat(input logic [RRPV_W-1:0] r);
    return (r == RRPV_MAX) ? r : r + RRPV_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      rrpv_o  <= RRPV_MAX;
      reuse_o <= 1'b0;
      sig_o   <= '0;
    end else if (fill_i) begin
      valid_o <= 1'b1;
      rrpv_o  <= fill_rrpv_i;
      reuse_o <= 1'b0;
      sig_o   <= fill_sig_i;
    end else if (hit_i && valid_o) begin
      rrpv_o  <= '0;
      reuse_o <= 1'b1;
    end else if (age_i && valid_o) begin
      rrpv_o  <= age_sat(rrpv_o);
    end
  end

endmodule

// File: rtl/rrip_search_fsm.sv
module rrip_search_fsm
  import rrip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_hit,
  input  logic any_free,
  input  logic any_distant,
  output logic req_ready,
  output logic miss_accept,
  output logic fill_ev,
  output logic victim_ev,
  output logic age_ev
);

  rrip_state_e state_q, state_d;

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    miss_accept = req_ready && req_valid && !req_hit;
    fill_ev     = (state_q == ST_SEARCH) && any_free;
    victim_ev   = (state_q == ST_SEARCH) && !any_free && any_distant;
    age_ev      = (state_q == ST_SEARCH) && !any_free && !any_distant;
    state_d     = state_q;
    if (miss_accept)            state_d = ST_SEARCH;
    else if (fill_ev || victim_ev) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/rrip_set_engine.sv
module rrip_set_engine
  import rrip_pkg::*;
#(
  parameter int WAYS   = 16,
  parameter int SIG_W  = 14,
  parameter int RRPV_W = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_hit,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [SIG_W-1:0]  req_sig,
  input  logic [RRPV_W-1:0] req_insert_rrpv,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [WAY_W-1:0]  resp_way,
  output logic              evict_valid,
  output logic              evict_reuse,
  output logic [SIG_W-1:0]  evict_sig
);

  function automatic logic is_distant(input logic [RRPV_W-1:0] r);
    return r == {RRPV_W{1'b1}};
  endfunction

  logic [WAYS-1:0]   way_valid, way_reuse;
  logic [RRPV_W-1:0] way_rrpv [WAYS];
  logic [SIG_W-1:0]  way_sig  [WAYS];
  logic [WAYS-1:0]   free_mask, distant_mask;
  logic              any_free, any_distant;
  logic [WAY_W-1:0]  free_idx, distant_idx, target_idx;

  // named internal events (also observed by the checker)
  logic hit_ev, miss_accept, fill_ev, victim_ev, age_ev, install_ev;

  logic [SIG_W-1:0]  pend_sig;
  logic [RRPV_W-1:0] pend_rrpv;

  assign hit_ev     = req_valid && req_ready && req_hit;
  assign install_ev = fill_ev || victim_ev;
  assign target_idx = any_free ? free_idx : distant_idx;

  rrip_search_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_hit     (req_hit),
    .any_free    (any_free),
    .any_distant (any_distant),
    .req_ready   (req_ready),
    .miss_accept (miss_accept),
    .fill_ev     (fill_ev),
    .victim_ev   (victim_ev),
    .age_ev      (age_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_sig  <= '0;
      pend_rrpv <= '0;
    end else if (miss_accept) begin
      pend_sig  <= req_sig;
      pend_rrpv <= req_insert_rrpv;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign free_mask[w]    = !way_valid[w];
    assign distant_mask[w] = way_valid[w] && is_distant(way_rrpv[w]);

    rrip_way_meta #(
      .RRPV_W (RRPV_W),
      .SIG_W  (SIG_W)
    ) u_meta (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit_ev && (req_way == WAY_W'(w))),
      .fill_i      (install_ev && (target_idx == WAY_W'(w))),
      .age_i       (age_ev),
      .fill_rrpv_i (pend_rrpv),
      .fill_sig_i  (pend_sig),
      .valid_o     (way_valid[w]),
      .rrpv_o      (way_rrpv[w]),
      .reuse_o     (way_reuse[w]),
      .sig_o       (way_sig[w])
    );
  end

  rrip_first_sel #(.N(WAYS)) u_free_sel (
    .mask  (free_mask),
    .found (any_free),
    .idx   (free_idx)
  );

  rrip_first_sel #(.N(WAYS)) u_distant_sel (
    .mask  (distant_mask),
    .found (any_distant),
    .idx   (distant_idx)
  );

  assign resp_valid  = install_ev;
  assign resp_way    = target_idx;
  assign evict_valid = victim_ev;
  assign evict_reuse = victim_ev && way_reuse[distant_idx];
  assign evict_sig   = victim_ev ? way_sig[distant_idx] : '0;

endmodule

// File: rtl/rrip_set_engine_chk.sv
module rrip_set_engine_chk #(
  parameter int RRPV_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_hit,
  input logic req_ready,
  input logic resp_valid,
  input logic evict_valid,
  input logic fill_ev,
  input logic victim_ev,
  input logic age_ev
);

  localparam int MAX_WAIT = (1 << RRPV_W);  // 1 search + up to 2^W-1 aging steps
  localparam int CW = $clog2(MAX_WAIT + 2) + 1;

  logic [CW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                    busy_run <= '0;
    else if (req_ready)            busy_run <= '0;
    else if (busy_run != {CW{1'b1}}) busy_run <= busy_run + CW'(1);
  end

  a_r9_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_hit) |=> !req_ready);

  a_r9_ready_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready);

  a_r2_hit_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hit) |=> req_ready);

  a_r7_evict_single: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !evict_valid);

  a_r7_evict_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> resp_valid);

  a_r4_fill_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |-> !evict_valid);

  a_r6_age_silent: assert property (@(posedge clk) disable iff (!rst_n)
    age_ev |-> (!resp_valid && !req_ready));

  a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_ev, victim_ev, age_ev}));

  a_r6_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= CW'(MAX_WAIT));

endmodule

bind rrip_set_engine rrip_set_engine_chk #(.RRPV_W(RRPV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_hit     (req_hit),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .evict_valid (evict_valid),
  .fill_ev     (fill_ev),
  .victim_ev   (victim_ev),
  .age_ev      (age_ev)
);

// File: tb/rrip_set_engine_tb.sv
module rrip_set_engine_tb;

  localparam int WAYS = 16;
  localparam int SIG_W = 14;
  localparam int RRPV_W = 2;
  localparam int WW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_hit;
  logic [WW-1:0]     req_way;
  logic [SIG_W-1:0]  req_sig;
  logic [RRPV_W-1:0] req_insert_rrpv;
  logic              req_ready, resp_valid, evict_valid, evict_reuse;
  logic [WW-1:0]     resp_way;
  logic [SIG_W-1:0]  evict_sig;

  rrip_set_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_way(req_way), .req_sig(req_sig), .req_insert_rrpv(req_insert_rrpv),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_way(resp_way),
    .evict_valid(evict_valid), .evict_reuse(evict_reuse), .evict_sig(evict_sig)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit m_valid [WAYS];
  int m_rrpv  [WAYS];
  bit m_reuse [WAYS];
  int m_sig   [WAYS];
  bit m_busy;
  int m_sig_l, m_ins_l;
  bit last_resp;
  int last_way;

  function automatic void check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < WAYS; i++) begin
      m_valid[i] = 0; m_rrpv[i] = 3; m_reuse[i] = 0; m_sig[i] = 0;
    end
    m_busy = 0;
  endfunction

  function automatic int first_empty();
    for (int i = 0; i < WAYS; i++) if (!m_valid[i]) return i;
    return -1;
  endfunction

  function automatic int first_far();
    for (int i = 0; i < WAYS; i++) if (m_valid[i] && m_rrpv[i] == 3) return i;
    return -1;
  endfunction

  task automatic compare();
    int e, f, w;
    bit er, ee;
    e = first_empty();
    f = first_far();
    er = m_busy && (e >= 0 || f >= 0);
    ee = m_busy && e < 0 && f >= 0;
    w = (e >= 0) ? e : f;
    check(req_ready == !m_busy, "R9", "req_ready", int'(req_ready), int'(!m_busy));
    check(resp_valid == er, (e >= 0) ? "R4" : "R6", "resp_valid", int'(resp_valid), int'(er));
    check(evict_valid == ee, "R7", "evict_valid", int'(evict_valid), int'(ee));
    if (er) check(int'(resp_way) == w, (e >= 0) ? "R10" : "R5", "resp_way", int'(resp_way), w);
    if (ee) begin
      check(evict_reuse == m_reuse[f], "R7", "evict_reuse", int'(evict_reuse), int'(m_reuse[f]));
      check(int'(evict_sig) == m_sig[f], "R8", "evict_sig", int'(evict_sig), m_sig[f]);
    end
    last_resp = resp_valid;
    last_way = int'(resp_way);
  endtask

  function automatic void model_update(bit v, bit hit, int way, int sig, int ins);
    int e, f, w;
    if (!m_busy) begin
      if (v && hit) begin
        if (m_valid[way]) begin m_rrpv[way] = 0; m_reuse[way] = 1; end
      end else if (v) begin
        m_busy = 1; m_sig_l = sig; m_ins_l = ins;
      end
    end else begin
      e = first_empty();
      f = first_far();
      if (e >= 0 || f >= 0) begin
        w = (e >= 0) ? e : f;
        m_valid[w] = 1; m_rrpv[w] = m_ins_l; m_reuse[w] = 0; m_sig[w] = m_sig_l;
        m_busy = 0;
      end else begin
        for (int i = 0; i < WAYS; i++) if (m_rrpv[i] < 3) m_rrpv[i]++;
      end
    end
  endfunction

  task automatic step(input bit v, input bit hit, input int way, input int sig, input int ins);
    req_valid = v; req_hit = hit; req_way = WW'(way);
    req_sig = SIG_W'(sig); req_insert_rrpv = RRPV_W'(ins);
    compare();
    @(posedge clk);
    model_update(v, hit, way, sig, ins);
    @(negedge clk);
  endtask

  task automatic do_miss(input int sig, input int ins, output int lat, output int way);
    step(1, 0, 0, sig, ins);
    lat = 0; way = -1;
    for (int k = 0; k < 8; k++) begin
      lat++;
      step(0, 0, 0, 0, 0);
      if (last_resp) begin way = last_way; break; end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int lat, way;
    rst_n = 0; req_valid = 0; req_hit = 0; req_way = '0; req_sig = '0; req_insert_rrpv = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1", "resp_valid", int'(resp_valid), 0);
    check(evict_valid == 1'b0, "R1", "evict_valid", int'(evict_valid), 0);

    // R3: hit to an empty way is dropped
    step(1, 1, 5, 0, 0);

    // R4 / R10: fills go to lowest empty way, one cycle after acceptance
    for (int i = 0; i < WAYS; i++) begin
      do_miss(256 + i, i % 4, lat, way);
      check(way == i, "R4", "fill way", way, i);
      check(lat == 1, "R4", "fill latency", lat, 1);
    end

    // R2: hits on a few ways
    step(1, 1, 3, 0, 0);
    step(1, 1, 7, 0, 0);
    step(1, 1, 11, 0, 0);

    // R5 / R7 / R8: evictions with export of the departing line
    for (int i = 0; i < 6; i++) do_miss(1000 + i, (i * 3) % 4, lat, way);

    // R9: hits and misses offered while busy are ignored
    step(1, 0, 0, 2000, 1);
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 2001, 0);
    while (m_busy) step(1, 1, 2, 0, 0);

    // R6: all ways at 0 -> three aging cycles, then way 0 evicted
    for (int i = 0; i < WAYS; i++) step(1, 1, i, 0, 0);
    do_miss(3000, 2, lat, way);
    check(lat == 4, "R6", "aging latency", lat, 4);
    check(way == 0, "R6", "victim after aging", way, 0);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 8);
      step(r != 0, r > 3, int'($urandom % WAYS), int'($urandom % (1 << SIG_W)), int'($urandom % 4));
    end
    while (m_busy) step(0, 0, 0, 0, 0);

    done = 1;
    finish_run();
  end

endmodule